// File: doc/BRIEF.md
# Decoding Shift Execution Unit

This block carries out the shift instructions of a 32-bit register-register instruction set. Each cycle it can accept one instruction word together with the two source operand values already read from the register file. It decodes the operation class and function fields, picks the shift distance and shifts the second operand. The distance comes either from a 5-bit immediate field in the instruction or from the low five bits of the first operand. Six operations are supported: left logical, right logical and right arithmetic, each with an immediate distance and with a register distance.

The result, the destination register index and an illegal-encoding flag are captured in an output register. They appear one clock edge after the input is presented, qualified by a valid strobe. An encoding that is not one of the six shifts produces a zero result with the illegal flag set. The surrounding pipeline can then raise an exception or drop the writeback. Register file access, writeback, hazards and the other arithmetic operations are handled elsewhere.

Top module: `shift_exec_unit`

## Requirements
- R1: An instruction whose bits 31 to 26 are not all zero is illegal: outIllegal is 1 and outResult is 0.
- R2: Bits 5 to 0 select the operation: 000000 left logical immediate, 000010 right logical immediate, 000011 right arithmetic immediate, 000100 left logical register, 000110 right logical register, 000111 right arithmetic register. Any other value is illegal, with outResult 0.
- R3: The immediate forms shift by instruction bits 10 to 6 read as unsigned, and rsVal has no effect on their result.
- R4: The register forms shift by rsVal bits 4 to 0 read as unsigned (0 to 31), and rsVal bits 31 to 5 have no effect.
- R5: A register form with a nonzero value in instruction bits 10 to 6 is illegal, with outResult 0.
- R6: Left shifts drop bits moved past bit 31 and fill the vacated low bits with zeros.
- R7: Logical right shifts fill the vacated high bits with zeros.
- R8: Arithmetic right shifts fill the vacated high bits with copies of rtVal bit 31.
- R9: A shift distance of 0 returns rtVal unchanged for every legal operation.
- R10: When inValid is high at a clock edge, the result, the destination index from instruction bits 15 to 11 and the illegal flag are registered at that edge, and outValid is 1 after that edge. outValid after each edge equals inValid at that edge.
- R11: A synchronous active-high reset clears outValid, outResult, outRd and outIllegal. While inValid is low, outResult, outRd and outIllegal keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| rsVal | input | 32 | First source operand value (register shift distance) |
| rtVal | input | 32 | Second source operand value (value to shift) |
| outValid | output | 1 | Registered outputs hold a new result |
| outResult | output | 32 | Shift result, zero when illegal |
| outRd | output | 5 | Destination register index from bits 15 to 11 |
| outIllegal | output | 1 | Instruction is not one of the six legal shifts |

## Verification
The assertions check the following on every cycle:
- a nonzero operation class, or a register form with a nonzero immediate field, always raises the illegal flag;
- an illegal result is always zero;
- outValid tracks inValid one edge later, and the outputs hold while no instruction is accepted;
- a zero distance returns the operand unchanged;
- an arithmetic right shift of a negative value keeps bit 31 set.

Only the bench's scenarios can show the exact shifted values, with the vacated bits filled correctly and the dropped bits lost. The same holds for the claim that the unused operand bits (all of rsVal for the immediate forms, its upper bits for the register forms) leave the result untouched. The bench also checks the distances 31 and 0 with directed cases.

// File: rtl/shift_pkg.sv
package shift_pkg;

  // Fixed instruction geometry; neighbouring decode logic depends on it.
  localparam int INSTR_W = 32;
  localparam int FN_W    = 6;
  localparam int CLS_W   = 6;
  localparam int IDX_W   = 5;

  localparam logic [FN_W-1:0] FN_LEFT_IMM   = 6'b000000;
  localparam logic [FN_W-1:0] FN_RLOG_IMM   = 6'b000010;
  localparam logic [FN_W-1:0] FN_RARI_IMM   = 6'b000011;
  localparam logic [FN_W-1:0] FN_LEFT_REG   = 6'b000100;
  localparam logic [FN_W-1:0] FN_RLOG_REG   = 6'b000110;
  localparam logic [FN_W-1:0] FN_RARI_REG   = 6'b000111;

  // Strobes from decode control to the shift datapath.
  typedef struct packed {
    logic shiftLeft;
    logic fillSign;
    logic useRegAmt;
    logic illegal;
  } shiftCtrl_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [CLS_W-1:0]    opClass,
  input  logic [FN_W-1:0]     funct,
  input  logic [AMT_W-1:0]    immAmt,
  output shiftCtrl_t          ctrl
);

  logic knownFunct;
  logic classOk;
  logic immFieldBad;

  always_comb begin
    ctrl       = '0;
    knownFunct = 1'b1;
    unique case (funct)
      FN_LEFT_IMM: begin ctrl.shiftLeft = 1'b1; end
      FN_RLOG_IMM: begin end
      FN_RARI_IMM: begin ctrl.fillSign  = 1'b1; end
      FN_LEFT_REG: begin ctrl.shiftLeft = 1'b1; ctrl.useRegAmt = 1'b1; end
      FN_RLOG_REG: begin ctrl.useRegAmt = 1'b1; end
      FN_RARI_REG: begin ctrl.fillSign  = 1'b1; ctrl.useRegAmt = 1'b1; end
      default:     begin knownFunct     = 1'b0; end
    endcase
    classOk     = (opClass == '0);
    immFieldBad = ctrl.useRegAmt && (immAmt != '0);
    ctrl.illegal = !classOk || !knownFunct || immFieldBad;
    if (ctrl.illegal) begin
      ctrl.shiftLeft = 1'b0;
      ctrl.fillSign  = 1'b0;
      ctrl.useRegAmt = 1'b0;
    end
  end

  // R1: a nonzero operation class never decodes as legal
  a_r1_class_illegal: assert property (@(posedge clk) disable iff (rst)
    (inValid && opClass != '0) |-> ctrl.illegal);

  // R5: register forms need an all-zero immediate field
  a_r5_regform_field: assert property (@(posedge clk) disable iff (rst)
    (inValid && funct[2] && funct[1:0] != 2'b01 && opClass == '0 && immAmt != '0) |-> ctrl.illegal);

  // R2: a legal operation never asks for a left shift with sign fill
  a_r2_no_left_sign: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ctrl.illegal) |-> !(ctrl.shiftLeft && ctrl.fillSign));

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  shiftCtrl_t        ctrl,
  input  logic [AMT_W-1:0]  immAmt,
  input  logic [AMT_W-1:0]  regAmt,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rtVal,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic [IDX_W-1:0]  outRd,
  output logic              outIllegal
);

  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] rtRev;
  logic [DATA_W-1:0] stageIn;
  logic [DATA_W-1:0] stageVal [AMT_W+1];
  logic [DATA_W-1:0] rightOut;
  logic [DATA_W-1:0] rightRev;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] resultNext;
  logic              fillBit;

  assign amt     = ctrl.useRegAmt ? regAmt : immAmt;
  assign fillBit = ctrl.fillSign & rtVal[DATA_W-1];

  // A left shift is done as a right shift of the bit-reversed operand.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign rtRev[b]    = rtVal[DATA_W-1-b];
    assign rightRev[b] = rightOut[DATA_W-1-b];
  end

  assign stageIn     = ctrl.shiftLeft ? rtRev : rtVal;
  assign stageVal[0] = stageIn;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stageVal[k+1] = amt[k]
      ? {{STEP{fillBit}}, stageVal[k][DATA_W-1:STEP]}
      : stageVal[k];
  end

  assign rightOut   = stageVal[AMT_W];
  assign shifted    = ctrl.shiftLeft ? rightRev : rightOut;
  assign resultNext = ctrl.illegal ? '0 : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outResult  <= '0;
      outRd      <= '0;
      outIllegal <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outResult  <= resultNext;
        outRd      <= rdIdx;
        outIllegal <= ctrl.illegal;
      end
    end
  end

  // R1/R2/R5: an illegal instruction always reports a zero result
  a_r2_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIllegal) |-> (outResult == '0));

  // R10: outValid follows inValid by one edge
  a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(inValid)));

  // R11: registered outputs hold while nothing is accepted
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outResult) && $stable(outRd) && $stable(outIllegal)));

  // R9: zero distance passes the operand through
  a_r9_zero_amount: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ctrl.illegal && amt == '0) |=> (outResult == $past(rtVal)));

  // R8: arithmetic right shift of a negative value stays negative
  a_r8_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ctrl.illegal && ctrl.fillSign && rtVal[DATA_W-1]) |=> outResult[DATA_W-1]);

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [31:0]        instr,
  input  logic [31:0]        rsVal,
  input  logic [31:0]        rtVal,
  output logic               outValid,
  output logic [31:0]        outResult,
  output logic [4:0]         outRd,
  output logic               outIllegal
);

  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  shiftCtrl_t ctrl;
  logic       unusedBits;

  assign unusedBits = ^{instr[25:16], rsVal[DATA_W-1:AMT_W]};

  shift_decode #(.AMT_W(AMT_W)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opClass (instr[31:26]),
    .funct   (instr[FN_W-1:0]),
    .immAmt  (instr[6+AMT_W-1:6]),
    .ctrl    (ctrl)
  );

  shift_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .ctrl       (ctrl),
    .immAmt     (instr[6+AMT_W-1:6]),
    .regAmt     (rsVal[AMT_W-1:0]),
    .rdIdx      (instr[15:11]),
    .rtVal      (rtVal),
    .outValid   (outValid),
    .outResult  (outResult),
    .outRd      (outRd),
    .outIllegal (outIllegal)
  );

endmodule

// File: tb/shift_exec_unit_tb.sv
module shift_exec_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic [4:0]  outRd;
  logic        outIllegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shift_exec_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .rsVal(rsVal), .rtVal(rtVal), .outValid(outValid),
    .outResult(outResult), .outRd(outRd), .outIllegal(outIllegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] cls, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {cls, rs, rt, rd, sh, fn};
  endfunction

  // Reference: {illegal, result}
  function automatic logic [32:0] refModel(input logic [31:0] ins, input logic [31:0] rs,
      input logic [31:0] rt);
    logic [4:0] sh;
    logic [4:0] amt;
    sh = ins[10:6];
    if (ins[31:26] != 6'd0) return {1'b1, 32'd0};
    case (ins[5:0])
      6'b000000: return {1'b0, rt << sh};
      6'b000010: return {1'b0, rt >> sh};
      6'b000011: return {1'b0, 32'($signed(rt) >>> sh)};
      6'b000100, 6'b000110, 6'b000111: begin
        if (sh != 5'd0) return {1'b1, 32'd0};
        amt = rs[4:0];
        if (ins[5:0] == 6'b000100) return {1'b0, rt << amt};
        if (ins[5:0] == 6'b000110) return {1'b0, rt >> amt};
        return {1'b0, 32'($signed(rt) >>> amt)};
      end
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Present one instruction, then check the registered outputs.
  task automatic runOne(input string tag, input logic [31:0] ins, input logic [31:0] rs,
      input logic [31:0] rt);
    logic [32:0] exp;
    exp = refModel(ins, rs, rt);
    @(negedge clk);
    instr = ins; rsVal = rs; rtVal = rt; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R10 valid"}, {31'd0, outValid}, 32'd1);
    check({tag, " result"}, outResult, exp[31:0]);
    check({tag, " illegal"}, {31'd0, outIllegal}, {31'd0, exp[32]});
    check({tag, " R10 rd"}, {27'd0, outRd}, {27'd0, ins[15:11]});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R11 reset valid", {31'd0, outValid}, 32'd0);
    check("R11 reset result", outResult, 32'd0);
    check("R11 reset rd", {27'd0, outRd}, 32'd0);
    rst = 1'b0;

    // Directed corner cases
    runOne("R6 left by 31", mk(0, 3, 4, 5, 31, 6'b000000), 32'hFFFF_FFFF, 32'h0000_0003);
    runOne("R7 right log by 31", mk(0, 0, 4, 6, 31, 6'b000010), 32'h0, 32'h8000_0000);
    runOne("R8 right ari by 31", mk(0, 0, 4, 7, 31, 6'b000011), 32'h0, 32'h8000_0000);
    runOne("R8 right ari pos", mk(0, 0, 4, 7, 4, 6'b000011), 32'h0, 32'h7F00_0000);
    runOne("R3 imm ignores rs", mk(0, 9, 4, 8, 4, 6'b000000), 32'hDEAD_BEEF, 32'h1234_5678);
    runOne("R4 reg upper bits", mk(0, 9, 4, 8, 0, 6'b000100), 32'hFFFF_FFE4, 32'h1234_5678);
    runOne("R4 R9 reg low zero", mk(0, 9, 4, 9, 0, 6'b000111), 32'h0000_0020, 32'h8765_4321);
    runOne("R9 imm zero ari", mk(0, 0, 4, 10, 0, 6'b000011), 32'h0, 32'hF0F0_0F0F);
    runOne("R4 srlv 31", mk(0, 1, 4, 11, 0, 6'b000110), 32'h0000_001F, 32'hFFFF_FFFF);
    runOne("R8 srav 16", mk(0, 1, 4, 12, 0, 6'b000111), 32'h0000_0010, 32'h8001_0000);
    runOne("R1 bad class", mk(6'b001000, 1, 4, 13, 3, 6'b000000), 32'h3, 32'hFFFF_FFFF);
    runOne("R2 bad funct", mk(0, 1, 4, 14, 3, 6'b000001), 32'h3, 32'hFFFF_FFFF);
    runOne("R2 bad funct 5", mk(0, 1, 4, 14, 0, 6'b000101), 32'h3, 32'hFFFF_FFFF);
    runOne("R5 reg form field", mk(0, 1, 4, 15, 2, 6'b000110), 32'h3, 32'hFFFF_FFFF);

    // R11: hold while inValid is low even as inputs change
    @(negedge clk);
    instr = mk(0, 0, 0, 31, 1, 6'b000000); rtVal = 32'h1; inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 hold valid", {31'd0, outValid}, 32'd0);
    check("R11 hold result", outResult, 32'd0);
    check("R11 hold rd", {27'd0, outRd}, 32'd15);
    check("R11 hold illegal", {31'd0, outIllegal}, 32'd1);

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [5:0] fnList [6];
      logic [5:0] cls;
      logic [5:0] fn;
      logic [4:0] sh;
      fnList = '{6'b000000, 6'b000010, 6'b000011, 6'b000100, 6'b000110, 6'b000111};
      cls = ($urandom % 8 == 0) ? 6'($urandom) : 6'd0;
      fn  = ($urandom % 10 == 0) ? 6'($urandom) : fnList[$urandom % 6];
      sh  = 5'($urandom);
      if (fn[2] && ($urandom % 6 != 0)) sh = 5'd0;
      runOne("R2 R6 R7 R8 random", mk(cls, 5'($urandom), 5'($urandom), 5'($urandom), sh, fn),
             $urandom, $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule